// File: doc/BRIEF.md
# Framed Serial Register Write Port

This block is the receive half of a three-wire serial slave port. An external master drives a serial clock, a data line, an active-low frame strobe and a target-select line. The block collects 24-bit words, most significant bit first. Each finished word goes either to a control register or to a calibration register. The block oversamples all four serial lines in its own system clock domain through two-flop synchronizers. It takes a bit on each rising edge of the synchronized serial clock while the frame strobe is low.

The master may release the frame strobe partway through a word and assert it again later. Shifting stops while the strobe is high. The bit position is kept, so the word carries on from where it stopped. The target-select value is captured with the first bit of a word. If it reads differently on any later bit, the word is dropped and a one-cycle protocol-error pulse is raised. When the 24th bit is taken, the word is written to its register and a one-cycle write-done pulse, tagged with the target, is raised.

The serial input cannot be stalled, so the block has no ready signal and applies no back-pressure. The write-done pulse acts as a valid strobe with no handshake. The register outputs hold their value until the next completed word for that target.

Top module: `fsr_write_port`

## Requirements
- R1: A synchronous reset (rst high at a clk edge) clears both register outputs to zero and clears the word in progress, and holds the done and error pulses low.
- R2: With select low (0 = control) during a whole word, 24 bits taken most significant bit first are written to ctrl_reg_o, and cal_reg_o keeps its value.
- R3: With select high (1 = calibration) during a whole word, the 24 bits are written to cal_reg_o, and ctrl_reg_o keeps its value.
- R4: A word with fewer than 24 bits taken never changes either register, and never raises wr_done_o.
- R5: While the frame strobe is high, serial clock edges are ignored and the bit count is held. After the strobe returns low, the next rising serial clock edge takes the next bit of the same word.
- R6: If select differs on any later bit from its value at the first bit of a word, proto_err_o pulses for one cycle, the word is discarded, and the next bit starts a new word.
- R7: Each completed word raises wr_done_o for exactly one clk cycle, with wr_tgt_o giving its target (0 control, 1 calibration).
- R8: The bit count returns to zero after the 24th bit, so several words can follow each other in one unbroken frame.
- R9: A reset in the middle of a word discards its bits. The next word after reset is received whole and aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Serial clock from master, idles low |
| sdata_i | input | 1 | Serial data, valid around the serial clock rising edge |
| frame_n_i | input | 1 | Frame strobe, active low, changes only while sclk_i is low |
| sel_i | input | 1 | Target select: 0 control, 1 calibration |
| ctrl_reg_o | output | 24 | Control register value |
| cal_reg_o | output | 24 | Calibration register value |
| wr_done_o | output | 1 | One-cycle pulse when a word is committed |
| wr_tgt_o | output | 1 | Target of the committed word, valid with wr_done_o |
| proto_err_o | output | 1 | One-cycle pulse when a word is dropped for a select change |

## Verification
The bench sweeps a walking-one word through every bit position for both targets. A design that reversed the bit order or wrote to the wrong register would put the bit in the wrong place, or change the other register. It splits a word across two frames, with serial clock pulses sent while the strobe is high. A design that restarted the count or shifted during the pause would store a misaligned word, and a design that wrote partial words would change the register early. It also flips select in the middle of a word, sends words back to back in one frame, and resets in the middle of a word. These catch a design that keeps stale bits or fails to wrap its bit counter.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
package fsr_pkg;
  localparam int unsigned WORD_W = 24;
  typedef enum logic {TGT_CTRL = 1'b0, TGT_CAL = 1'b1} tgt_e;
endpackage

// File: rtl/fsr_sync.sv
`timescale 1ns/1ps
module fsr_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else if (s == 0) stg[s] <= d_i;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/fsr_shifter.sv
`timescale 1ns/1ps
module fsr_shifter
  import fsr_pkg::*;
#(
  parameter int unsigned W = fsr_pkg::WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_s,
  input  logic         sdata_s,
  input  logic         frame_n_s,
  input  logic         sel_s,
  output logic [W-1:0] word_o,
  output logic         done_o,
  output tgt_e         tgt_o,
  output logic         err_o
);
  localparam int unsigned CNT_W = (W > 1) ? $clog2(W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic             sclk_q;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     shreg;
  logic [W-1:0]     shnext;
  logic             sel_lat;
  logic             take;
  logic             mismatch;

  assign take     = sclk_s && !sclk_q && !frame_n_s;
  assign mismatch = (cnt != '0) && (sel_s != sel_lat);

  always_comb begin
    shnext = {shreg[W-2:0], sdata_s};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      cnt     <= '0;
      shreg   <= '0;
      sel_lat <= 1'b0;
      word_o  <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
      tgt_o   <= TGT_CTRL;
    end else begin
      sclk_q <= sclk_s;
      done_o <= 1'b0;
      err_o  <= 1'b0;
      if (take) begin
        if (mismatch) begin
          err_o <= 1'b1;
          cnt   <= '0;
          shreg <= '0;
        end else begin
          if (cnt == '0) sel_lat <= sel_s;
          if (cnt == LAST) begin
            word_o <= shnext;
            done_o <= 1'b1;
            tgt_o  <= tgt_e'(sel_s);
            cnt    <= '0;
            shreg  <= '0;
          end else begin
            shreg <= shnext;
            cnt   <= cnt + CNT_W'(1);
          end
        end
      end
    end
  end

  assert_cnt_range_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST);
  assert_pause_hold_R5: assert property (@(posedge clk) disable iff (rst)
    frame_n_s |=> $stable(cnt) && $stable(shreg));
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_err_no_commit_R6: assert property (@(posedge clk) disable iff (rst)
    !(err_o && done_o));
  assert_err_restart_R6: assert property (@(posedge clk) disable iff (rst)
    err_o |-> cnt == '0);
endmodule

// File: rtl/fsr_regs.sv
`timescale 1ns/1ps
module fsr_regs
  import fsr_pkg::*;
#(
  parameter int unsigned W = fsr_pkg::WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] word_i,
  input  logic         we_i,
  input  tgt_e         tgt_i,
  output logic [W-1:0] ctrl_o,
  output logic [W-1:0] cal_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o <= '0;
      cal_o  <= '0;
    end else if (we_i) begin
      if (tgt_i == TGT_CTRL) ctrl_o <= word_i;
      else cal_o <= word_i;
    end
  end

  assert_reg_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(ctrl_o) && $stable(cal_o));
  assert_ctrl_only_R2: assert property (@(posedge clk) disable iff (rst)
    (we_i && tgt_i == TGT_CTRL) |=> $stable(cal_o));
  assert_cal_only_R3: assert property (@(posedge clk) disable iff (rst)
    (we_i && tgt_i == TGT_CAL) |=> $stable(ctrl_o));
endmodule

// File: rtl/fsr_write_port.sv
`timescale 1ns/1ps
module fsr_write_port
  import fsr_pkg::*;
#(
  parameter int unsigned W = fsr_pkg::WORD_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk_i,
  input  logic         sdata_i,
  input  logic         frame_n_i,
  input  logic         sel_i,
  output logic [W-1:0] ctrl_reg_o,
  output logic [W-1:0] cal_reg_o,
  output logic         wr_done_o,
  output logic         wr_tgt_o,
  output logic         proto_err_o
);
  logic [3:0]   raw_in;
  logic [3:0]   syn;
  logic [W-1:0] word;
  logic         done;
  tgt_e         tgt;
  logic         err;

  assign raw_in = {sclk_i, sdata_i, frame_n_i, sel_i};

  fsr_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (raw_in),
    .q_o (syn)
  );

  fsr_shifter #(.W(W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .sclk_s    (syn[3]),
    .sdata_s   (syn[2]),
    .frame_n_s (syn[1]),
    .sel_s     (syn[0]),
    .word_o    (word),
    .done_o    (done),
    .tgt_o     (tgt),
    .err_o     (err)
  );

  fsr_regs #(.W(W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .word_i (word),
    .we_i   (done),
    .tgt_i  (tgt),
    .ctrl_o (ctrl_reg_o),
    .cal_o  (cal_reg_o)
  );

  assign wr_done_o   = done;
  assign wr_tgt_o    = tgt;
  assign proto_err_o = err;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (ctrl_reg_o == '0) && (cal_reg_o == '0) && !wr_done_o && !proto_err_o);
endmodule

// File: tb/tb_fsr_write_port.sv
`timescale 1ns/1ps
module tb_fsr_write_port;
  localparam int W = 24;
  localparam int HP = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdata = 1'b0, frame_n = 1'b1, sel = 1'b0;
  logic [W-1:0] ctrl, cal;
  logic done, tgt, err;

  int checks = 0, fails = 0;
  int done_cnt = 0, err_cnt = 0;
  logic last_tgt = 1'b0;
  bit finished = 1'b0;

  always #HP clk = ~clk;

  fsr_write_port dut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sdata_i(sdata),
    .frame_n_i(frame_n), .sel_i(sel), .ctrl_reg_o(ctrl), .cal_reg_o(cal),
    .wr_done_o(done), .wr_tgt_o(tgt), .proto_err_o(err)
  );

  // pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst && done) begin done_cnt++; last_tgt = tgt; end
    if (!rst && err) err_cnt++;
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic send_bit(logic b, logic s);
    sdata = b; sel = s;
    cyc(4); sclk = 1'b1;
    cyc(4); sclk = 1'b0;
  endtask

  // send bits hi..lo of w (MSB first)
  task automatic send_range(logic [W-1:0] w, int hi, int lo, logic s);
    for (int b = hi; b >= lo; b--) send_bit(w[b], s);
  endtask

  task automatic frame(logic lo);
    cyc(2); frame_n = ~lo; cyc(2);
  endtask

  task automatic settle();
    cyc(10);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] exp_ctrl, exp_cal, w;
    int d0, e0;
    cyc(4); rst = 1'b0; settle();
    // R1 reset state
    chk(ctrl == 0, "R1 ctrl", ctrl, 0);
    chk(cal == 0, "R1 cal", cal, 0);
    chk(!done && !err, "R1 pulses", {done, err}, 0);
    exp_ctrl = '0; exp_cal = '0;

    // sweep: walking one mixed with an index pattern, both targets
    for (int t = 0; t < 2; t++) begin
      for (int i = 0; i < W; i++) begin
        w = (W'(1) << i) ^ (W'(i) * W'(24'h010203));
        d0 = done_cnt;
        frame(1'b1); send_range(w, W-1, 0, t[0]); frame(1'b0);
        settle();
        if (t == 0) exp_ctrl = w; else exp_cal = w;
        chk(ctrl == exp_ctrl, t == 0 ? "R2 ctrl word" : "R3 ctrl kept", ctrl, exp_ctrl);
        chk(cal == exp_cal, t == 0 ? "R2 cal kept" : "R3 cal word", cal, exp_cal);
        chk(done_cnt == d0 + 1, "R7 one pulse", done_cnt - d0, 1);
        chk(last_tgt == t[0], "R7 target", last_tgt, t);
      end
    end

    // R4 / R5: split word with ignored serial clocks during the pause
    w = 24'hC35A96; d0 = done_cnt;
    frame(1'b1); send_range(w, 23, 14, 1'b0); frame(1'b0);
    for (int k = 0; k < 3; k++) send_bit(1'b1, 1'b0);
    settle();
    chk(ctrl == exp_ctrl, "R4 partial no write", ctrl, exp_ctrl);
    chk(done_cnt == d0, "R4 no done", done_cnt - d0, 0);
    frame(1'b1); send_range(w, 13, 0, 1'b0); frame(1'b0);
    settle(); exp_ctrl = w;
    chk(ctrl == w, "R5 resumed word", ctrl, w);
    chk(done_cnt == d0 + 1, "R5 one done", done_cnt - d0, 1);

    // R6: select changes mid-word
    d0 = done_cnt; e0 = err_cnt;
    frame(1'b1); send_range(24'hFFFFFF, 23, 19, 1'b0); send_bit(1'b1, 1'b1);
    settle();
    chk(err_cnt == e0 + 1, "R6 error pulse", err_cnt - e0, 1);
    chk(ctrl == exp_ctrl && cal == exp_cal, "R6 regs kept", ctrl, exp_ctrl);
    chk(done_cnt == d0, "R6 no done", done_cnt - d0, 0);
    w = 24'h1E2D3C;
    send_range(w, 23, 0, 1'b0); frame(1'b0); settle(); exp_ctrl = w;
    chk(ctrl == w, "R6 fresh word after error", ctrl, w);

    // R8: two words back to back in one frame
    d0 = done_cnt;
    frame(1'b1);
    send_range(24'h0F0F0F, 23, 0, 1'b1);
    send_range(24'h7654A1, 23, 0, 1'b1);
    frame(1'b0); settle(); exp_cal = 24'h7654A1;
    chk(cal == exp_cal, "R8 second word", cal, exp_cal);
    chk(done_cnt == d0 + 2, "R8 two dones", done_cnt - d0, 2);

    // R9: reset mid-word
    frame(1'b1); send_range(24'hABCDEF, 23, 17, 1'b1); frame(1'b0);
    @(negedge clk); rst = 1'b1; cyc(3); @(negedge clk); rst = 1'b0;
    settle();
    chk(ctrl == 0 && cal == 0, "R9 reset clears regs", {ctrl, cal}, 0);
    w = 24'h800001;
    frame(1'b1); send_range(w, 23, 0, 1'b1); frame(1'b0); settle();
    chk(cal == w, "R9 aligned after reset", cal, w);
    chk(ctrl == 0, "R9 ctrl kept", ctrl, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule